// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command side of a parallel NOR flash that accepts the classic unlock-cycle command set. Every host write supplies an address and a data value. The block decodes those writes against an address-qualified, multi-cycle protocol. A write either advances a command sequence or returns the block to plain read mode. Completed sequences program words of a small on-chip storage array, or erase one sector or the whole array.

The read path always answers one cycle after the read strobe. Its source follows the current command state. It is normally the storage array, but it can also be an identification word, the erase status byte, or a computed query table. An unlock-bypass mode lets software program word after word without repeating the unlock pair. A query mode exposes a table that describes the device geometry.

Command addresses are word offsets. A word offset is the byte address shifted right by log2 of the device width in bytes, taken modulo the array size. The command byte is the low 8 bits of the write data.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read mode with bypass cleared, and every storage word reads all ones.
- R2: A read strobe returns its data on `rd_data` on the next clock cycle, and `rd_data` holds its value until the next read.
- R3: The sequence 0xAA at word offset UNLOCK_A, then 0x55 at word offset UNLOCK_B, then 0xA0 at UNLOCK_A arms a program. The next write stores (old word AND written data) at its word offset, then the block returns to read mode.
- R4: If the first cycle is not 0xAA at UNLOCK_A, or the second is not 0x55 at UNLOCK_B, the block returns to read mode, and a later data write programs nothing.
- R5: The third cycle is accepted only at UNLOCK_A, and only with 0x80, 0x90, 0xA0 or 0x20. Any other value, or any other address, returns the block to read mode.
- R6: Command byte 0xF0 returns the block to read mode and clears bypass. This applies in every state except two: in the armed program cycle it is treated as data, and during an erase it is ignored.
- R7: In autoselect (entered with 0x90), reads decode the index (byte address bits 7..0 shifted by the width). Index 0 returns ID_0 and index 1 returns ID_1. Index 2 returns 0. Indices 0x0E and 0x0F return ID_2 and ID_3, unless that word is all ones, in which case array data is returned. Every other index returns array data.
- R8: Writing 0x98 at word offset 0x55 in read mode or in autoselect enters query mode. Query reads by index return 'Q','R','Y' at 0x10 to 0x12, 0x02 at 0x13, 0x31 at 0x15, and log2 of the chip bytes at 0x27. They return 1 at 0x2C, the sector count minus one at 0x2D/0x2E, and the sector bytes divided by 256 at 0x2F/0x30. Every other index returns 0. Any write leaves query mode to read mode.
- R9: After 0x80, a second 0xAA/0x55 unlock pair arms an erase. Then 0x10 at UNLOCK_A sets every word to all ones, and 0x30 at any address sets every word of the sector containing that address to all ones. The erase writes one word per cycle and ignores all writes while it runs. Reads during the erase return a status value with bit 7 = 0 and bit 6 toggling on each read, starting at 0.
- R10: Command 0x20 enters bypass. In bypass the command cycle needs no unlock pair and no address check, and a program returns to the command cycle. Writing 0x00 in autoselect under bypass exits to read mode with bypass cleared.
- R11: Addresses wrap modulo the chip size, so an address with bits above the array range selects the same word for commands, programs and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8*DEV_BYTES | Write data; the low byte is the command byte |
| rd_data | output | 8*DEV_BYTES | Read data, valid the cycle after `rd_en` |

## Verification
A write changes the command state at the clock edge that samples it. A read returns data at the edge after its strobe. The bench therefore drives each strobe for one cycle from a falling edge and samples `rd_data` at the next falling edge. An erase starts at the edge after its confirm write and finishes after one cycle per word: 32 cycles for a sector and 128 for the chip in the default setup. Status reads are made inside that window, and array sweeps wait well past its end. Writes during an erase are checked by confirming that the erase still completes fully and that read mode follows.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK2,
        ST_CMD,
        ST_PROG,
        ST_ERU1,
        ST_ERU2,
        ST_ERCMD,
        ST_BUSY,
        ST_AUTO,
        ST_QUERY
    } seq_state_e;

    typedef enum logic {
        SRC_ARRAY,
        SRC_AUX
    } rd_src_e;

    typedef struct packed {
        logic start;
        logic chip;
    } erase_req_t;

    localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B  = 8'h55;
    localparam logic [7:0] CMD_ERSETUP = 8'h80;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_CHIPER  = 8'h10;
    localparam logic [7:0] CMD_SECTER  = 8'h30;
    localparam logic [7:0] CMD_BYPEXIT = 8'h00;
    localparam int         QUERY_OFF   = 8'h55;

    function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                              input int chip_log2,
                                              input int nsect,
                                              input int sect_bytes);
        int n1;
        n1 = nsect - 1;
        case (idx)
            8'h10:   query_byte = 8'h51;
            8'h11:   query_byte = 8'h52;
            8'h12:   query_byte = 8'h59;
            8'h13:   query_byte = 8'h02;
            8'h15:   query_byte = 8'h31;
            8'h27:   query_byte = 8'(chip_log2);
            8'h2C:   query_byte = 8'h01;
            8'h2D:   query_byte = 8'(n1);
            8'h2E:   query_byte = 8'(n1 >> 8);
            8'h2F:   query_byte = 8'(sect_bytes >> 8);
            8'h30:   query_byte = 8'(sect_bytes >> 16);
            default: query_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_seq_array.sv
module nor_seq_array #(
    parameter int WORDS = 128,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          and_mode,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                mem[waddr] <= and_mode ? (mem[waddr] & wdata) : wdata;
            end
            if (re) begin
                rdata <= mem[raddr];
            end
        end
    end

    // Shadow of the word before a program, used only by the check below.
    logic          chk_prog_q;
    logic [AW-1:0] chk_addr_q;
    logic [DW-1:0] chk_old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_prog_q <= 1'b0;
            chk_addr_q <= '0;
            chk_old_q  <= '0;
        end else begin
            chk_prog_q <= we && and_mode;
            chk_addr_q <= waddr;
            chk_old_q  <= mem[waddr];
        end
    end

    // R3: a program can only clear bits of the stored word
    a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
        chk_prog_q |-> ((mem[chk_addr_q] & ~chk_old_q) == '0));

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter int WORDS      = 128,
    parameter int SECT_WORDS = 32,
    parameter int DW         = 16,
    parameter int UNLOCK_A   = 'h55,
    parameter int UNLOCK_B   = 'h2A,
    localparam int OW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [OW-1:0] woff,
    input  logic [DW-1:0] wdata,
    output seq_state_e    state,
    output logic          bypass,
    output logic          arr_we,
    output logic          arr_and,
    output logic [OW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output logic          erase_start
);

    localparam logic [OW-1:0] SECT_MASK = OW'(SECT_WORDS - 1);
    localparam logic [OW-1:0] LAST_WORD = OW'(WORDS - 1);

    seq_state_e    st_n;
    logic          byp_n;
    erase_req_t    ereq;
    logic [7:0]    cmd;
    logic          at_a, at_b, at_q;
    logic [OW-1:0] er_cnt, er_last_q;
    logic          er_last;

    assign cmd     = wdata[7:0];
    assign at_a    = (woff == OW'(UNLOCK_A));
    assign at_b    = (woff == OW'(UNLOCK_B));
    assign at_q    = (woff == OW'(QUERY_OFF));
    assign er_last = (er_cnt == er_last_q);

    always_comb begin
        st_n       = state;
        byp_n      = bypass;
        ereq.start = 1'b0;
        ereq.chip  = 1'b0;
        if (state == ST_BUSY) begin
            if (er_last) begin
                st_n = bypass ? ST_CMD : ST_READ;
            end
        end else if (wr_en) begin
            if (state != ST_PROG && cmd == CMD_RESET) begin
                st_n  = ST_READ;
                byp_n = 1'b0;
            end else begin
                st_n  = ST_READ;
                byp_n = 1'b0;
                case (state)
                    ST_READ: begin
                        if (at_q && cmd == CMD_QUERY) begin
                            st_n = ST_QUERY;
                        end else if (at_a && cmd == CMD_UNLK_A) begin
                            st_n = ST_UNLK2;
                        end
                    end
                    ST_UNLK2: begin
                        if (at_b && cmd == CMD_UNLK_B) st_n = ST_CMD;
                    end
                    ST_CMD: begin
                        if (bypass || at_a) begin
                            byp_n = bypass;
                            case (cmd)
                                CMD_BYPASS: begin
                                    st_n  = ST_CMD;
                                    byp_n = 1'b1;
                                end
                                CMD_ERSETUP: st_n = ST_ERU1;
                                CMD_AUTOSEL: st_n = ST_AUTO;
                                CMD_PROGRAM: st_n = ST_PROG;
                                default: begin
                                    st_n  = ST_READ;
                                    byp_n = 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_PROG: begin
                        if (bypass) begin
                            st_n  = ST_CMD;
                            byp_n = 1'b1;
                        end
                    end
                    ST_ERU1: begin
                        if (at_a && cmd == CMD_UNLK_A) begin
                            st_n  = ST_ERU2;
                            byp_n = bypass;
                        end
                    end
                    ST_ERU2: begin
                        if (at_b && cmd == CMD_UNLK_B) begin
                            st_n  = ST_ERCMD;
                            byp_n = bypass;
                        end
                    end
                    ST_ERCMD: begin
                        if ((cmd == CMD_CHIPER && at_a) || cmd == CMD_SECTER) begin
                            st_n       = ST_BUSY;
                            byp_n      = bypass;
                            ereq.start = 1'b1;
                            ereq.chip  = (cmd == CMD_CHIPER);
                        end
                    end
                    ST_AUTO: begin
                        if (!(bypass && cmd == CMD_BYPEXIT) && at_q && cmd == CMD_QUERY) begin
                            st_n  = ST_QUERY;
                            byp_n = bypass;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READ;
            bypass    <= 1'b0;
            er_cnt    <= '0;
            er_last_q <= '0;
        end else begin
            state  <= st_n;
            bypass <= byp_n;
            if (ereq.start) begin
                er_cnt    <= ereq.chip ? '0 : (woff & ~SECT_MASK);
                er_last_q <= ereq.chip ? LAST_WORD : (woff | SECT_MASK);
            end else if (state == ST_BUSY) begin
                er_cnt <= er_cnt + 1'b1;
            end
        end
    end

    assign arr_we      = (state == ST_BUSY) || (wr_en && state == ST_PROG);
    assign arr_and     = (state != ST_BUSY);
    assign arr_waddr   = (state == ST_BUSY) ? er_cnt : woff;
    assign arr_wdata   = (state == ST_BUSY) ? '1 : wdata;
    assign erase_start = ereq.start;

    // R6: reset command outside program/erase returns to read with bypass off
    a_r6_f0_exit: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[7:0] == CMD_RESET && state != ST_PROG && state != ST_BUSY)
        |=> (state == ST_READ && !bypass));

    // R9: an erase in progress keeps running one word per cycle
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && !er_last) |=> (state == ST_BUSY && er_cnt == $past(er_cnt) + 1'b1));

    // R10: bypass never survives a return to read mode
    a_r10_bypass_not_idle: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (state != ST_READ));

endmodule

// File: rtl/nor_seq_rdmux.sv
module nor_seq_rdmux
    import nor_seq_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CHIP_LOG2  = 8,
    parameter int NSECT      = 4,
    parameter int SECT_BYTES = 64,
    parameter int ID_0       = 'h0001,
    parameter int ID_1       = 'h227E,
    parameter int ID_2       = 'h2210,
    parameter int ID_3       = 'hFFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [7:0]    lo_idx,
    input  seq_state_e    state,
    input  logic          erase_start,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data
);

    localparam logic [DW-1:0] IDW0 = DW'(ID_0);
    localparam logic [DW-1:0] IDW1 = DW'(ID_1);
    localparam logic [DW-1:0] IDW2 = DW'(ID_2);
    localparam logic [DW-1:0] IDW3 = DW'(ID_3);

    rd_src_e       src_q;
    logic [DW-1:0] aux_q;
    logic          tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_ARRAY;
            aux_q <= '0;
            tog   <= 1'b0;
        end else begin
            if (rd_en) begin
                src_q <= SRC_ARRAY;
                case (state)
                    ST_AUTO: begin
                        case (lo_idx)
                            8'h00: begin src_q <= SRC_AUX; aux_q <= IDW0; end
                            8'h01: begin src_q <= SRC_AUX; aux_q <= IDW1; end
                            8'h02: begin src_q <= SRC_AUX; aux_q <= '0;   end
                            8'h0E: begin
                                if (IDW2 != '1) begin src_q <= SRC_AUX; aux_q <= IDW2; end
                            end
                            8'h0F: begin
                                if (IDW3 != '1) begin src_q <= SRC_AUX; aux_q <= IDW3; end
                            end
                            default: ;
                        endcase
                    end
                    ST_QUERY: begin
                        src_q <= SRC_AUX;
                        aux_q <= DW'(query_byte(lo_idx, CHIP_LOG2, NSECT, SECT_BYTES));
                    end
                    ST_BUSY: begin
                        src_q <= SRC_AUX;
                        aux_q <= DW'({tog, 6'b0});
                        tog   <= ~tog;
                    end
                    default: ;
                endcase
            end
            if (erase_start) begin
                tog <= 1'b0;
            end
        end
    end

    assign rd_data = (src_q == SRC_AUX) ? aux_q : arr_rdata;

    // R2: output holds between read strobes
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int DEV_BYTES  = 2,
    parameter int SECT_BYTES = 64,
    parameter int NSECT      = 4,
    parameter int ADDR_W     = 12,
    parameter int UNLOCK_A   = 'h55,
    parameter int UNLOCK_B   = 'h2A,
    parameter int ID_0       = 'h0001,
    parameter int ID_1       = 'h227E,
    parameter int ID_2       = 'h2210,
    parameter int ID_3       = 'hFFFF,
    localparam int DW        = 8 * DEV_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_data
);

    localparam int SH         = $clog2(DEV_BYTES);
    localparam int CHIP_BYTES = SECT_BYTES * NSECT;
    localparam int WORDS      = CHIP_BYTES / DEV_BYTES;
    localparam int SECT_WORDS = SECT_BYTES / DEV_BYTES;
    localparam int OW         = $clog2(WORDS);
    localparam int CHIP_LOG2  = $clog2(CHIP_BYTES);

    logic [OW-1:0] woff;
    logic [7:0]    lo_idx;
    seq_state_e    state;
    logic          bypass;
    logic          arr_we, arr_and, erase_start;
    logic [OW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata, arr_rdata;

    assign woff   = OW'(addr >> SH);
    assign lo_idx = 8'(addr[7:0] >> SH);

    nor_seq_fsm #(
        .WORDS(WORDS), .SECT_WORDS(SECT_WORDS), .DW(DW),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) fsm_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .woff(woff), .wdata(wdata),
        .state(state), .bypass(bypass), .arr_we(arr_we), .arr_and(arr_and),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .erase_start(erase_start)
    );

    nor_seq_array #(.WORDS(WORDS), .DW(DW)) array_i (
        .clk(clk), .rst(rst), .we(arr_we), .and_mode(arr_and),
        .waddr(arr_waddr), .wdata(arr_wdata), .re(rd_en), .raddr(woff),
        .rdata(arr_rdata)
    );

    nor_seq_rdmux #(
        .DW(DW), .CHIP_LOG2(CHIP_LOG2), .NSECT(NSECT), .SECT_BYTES(SECT_BYTES),
        .ID_0(ID_0), .ID_1(ID_1), .ID_2(ID_2), .ID_3(ID_3)
    ) rdmux_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .lo_idx(lo_idx), .state(state),
        .erase_start(erase_start), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    // R1: width and geometry must give a power-of-two array covering the low 256 bytes
    initial begin
        a_r1_geometry: assert ((WORDS & (WORDS - 1)) == 0 && ADDR_W >= 8);
    end

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

    localparam int UA = 'h55;
    localparam int UB = 'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m [128];

    always #5 clk = ~clk;

    nor_cmd_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'(UA * 2), 16'h00AA);
        wr(12'(UB * 2), 16'h0055);
    endtask

    task automatic program_word(input int w, input logic [15:0] d);
        unlock();
        wr(12'(UA * 2), 16'h00A0);
        wr(12'(w * 2), d);
        m[w] = m[w] & d;
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v;
        int bad = 0;
        logic [15:0] first_got = '0, first_exp = '0;
        for (int w = 0; w < 128; w++) begin
            rd(12'(w * 2), v);
            if (v !== m[w] && bad == 0) begin
                first_got = v; first_exp = m[w];
            end
            if (v !== m[w]) bad++;
        end
        chk(tag, first_got, first_exp);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int w = 0; w < 128; w++) m[w] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 and R2: erased contents after reset, one-cycle read
        sweep("R1 reset contents");
        rd(12'h010, v);
        chk("R2 read latency", v, 16'hFFFF);
        @(negedge clk);
        chk("R2 hold without read", rd_data, 16'hFFFF);

        // R3: program every word
        for (int w = 0; w < 128; w++) program_word(w, 16'(w * 16'h0123) ^ 16'hA5C3);
        sweep("R3 program sweep");
        program_word(5, 16'h0F0F);
        program_word(77, 16'h3C3C);
        rd(12'(5 * 2), v);  chk("R3 AND merge w5", v, m[5]);
        rd(12'(77 * 2), v); chk("R3 AND merge w77", v, m[77]);

        // R4: bad second unlock cycle
        wr(12'(UA * 2), 16'h00AA);
        wr(12'h010, 16'h0055);
        wr(12'(UA * 2), 16'h00A0);
        wr(12'(9 * 2), 16'h0000);
        rd(12'(9 * 2), v); chk("R4 bad unlock B", v, m[9]);
        // R4: bad first unlock data
        wr(12'(UA * 2), 16'h00AB);
        wr(12'(UB * 2), 16'h0055);
        wr(12'(UA * 2), 16'h00A0);
        wr(12'(10 * 2), 16'h0000);
        rd(12'(10 * 2), v); chk("R4 bad unlock A", v, m[10]);

        // R5: unknown command and wrong command address
        unlock();
        wr(12'(UA * 2), 16'h0033);
        wr(12'(11 * 2), 16'h0000);
        rd(12'(11 * 2), v); chk("R5 unknown command", v, m[11]);
        unlock();
        wr(12'(12 * 2), 16'h00A0);
        wr(12'(12 * 2), 16'h0000);
        rd(12'(12 * 2), v); chk("R5 wrong command address", v, m[12]);

        // R6: reset command mid-sequence, and as program data
        wr(12'(UA * 2), 16'h00AA);
        wr(12'(UB * 2), 16'h00F0);
        wr(12'(UA * 2), 16'h00A0);
        wr(12'(13 * 2), 16'h0000);
        rd(12'(13 * 2), v); chk("R6 reset mid unlock", v, m[13]);
        program_word(14, 16'h00F0);
        rd(12'(14 * 2), v); chk("R6 F0 as program data", v, m[14]);

        // R7: autoselect decode
        unlock();
        wr(12'(UA * 2), 16'h0090);
        rd(12'h000, v); chk("R7 id0", v, 16'h0001);
        rd(12'h002, v); chk("R7 id1", v, 16'h227E);
        rd(12'h004, v); chk("R7 protect", v, 16'h0000);
        rd(12'h01C, v); chk("R7 id2", v, 16'h2210);
        rd(12'h01E, v); chk("R7 id3 all ones gives array", v, m[15]);
        rd(12'h020, v); chk("R7 other index array", v, m[16]);
        // R8: query from autoselect
        wr(12'h0AA, 16'h0098);
        rd(12'h020, v); chk("R8 query Q from autoselect", v, 16'h0051);
        wr(12'h000, 16'h0000);
        rd(12'h020, v); chk("R8 exit on write", v, m[16]);

        // R8: query from read mode, table sweep
        wr(12'h0AA, 16'h0098);
        for (int i = 0; i < 96; i++) begin
            logic [15:0] e;
            case (i)
                'h10: e = 16'h51; 'h11: e = 16'h52; 'h12: e = 16'h59;
                'h13: e = 16'h02; 'h15: e = 16'h31; 'h27: e = 16'd8;
                'h2C: e = 16'h01; 'h2D: e = 16'd3;
                default: e = 16'h0000;
            endcase
            rd(12'(i * 2), v);
            chk($sformatf("R8 query index %0h", i), v, e);
        end
        wr(12'h000, 16'h0000);
        rd(12'h000, v); chk("R8 back to array", v, m[0]);

        // R9: sector erase with status and ignored writes
        unlock();
        wr(12'(UA * 2), 16'h0080);
        unlock();
        wr(12'(70 * 2), 16'h0030);
        rd(12'h000, v); chk("R9 status first", v, 16'h0000);
        rd(12'h000, v); chk("R9 status toggled", v, 16'h0040);
        wr(12'h000, 16'h00F0);
        wr(12'(UA * 2), 16'h00AA);
        repeat (100) @(negedge clk);
        for (int w = 64; w < 96; w++) m[w] = 16'hFFFF;
        sweep("R9 sector erase result");
        program_word(80, 16'h1234);
        rd(12'(80 * 2), v); chk("R9 read mode after erase", v, 16'h1234);

        // R9: chip erase
        unlock();
        wr(12'(UA * 2), 16'h0080);
        unlock();
        wr(12'(UA * 2), 16'h0010);
        rd(12'h000, v); chk("R9 chip status", v, 16'h0000);
        repeat (200) @(negedge clk);
        for (int w = 0; w < 128; w++) m[w] = 16'hFFFF;
        sweep("R9 chip erase result");

        // R10: bypass programming
        unlock();
        wr(12'(UA * 2), 16'h0020);
        for (int k = 0; k < 8; k++) begin
            wr(12'(k * 6), 16'h00A0);
            wr(12'((20 + k) * 2), 16'(16'h8001 << k));
            m[20 + k] = m[20 + k] & 16'(16'h8001 << k);
        end
        sweep("R10 bypass programs");
        wr(12'h010, 16'h0090);
        rd(12'h000, v); chk("R10 autoselect in bypass", v, 16'h0001);
        wr(12'h010, 16'h0000);
        wr(12'h010, 16'h00A0);
        wr(12'(30 * 2), 16'h0000);
        rd(12'(30 * 2), v); chk("R10 bypass exit", v, m[30]);

        // R11: aliased addresses wrap modulo chip size
        wr(12'(UA * 2 + 256), 16'h00AA);
        wr(12'(UB * 2 + 512), 16'h0055);
        wr(12'(UA * 2 + 1024), 16'h00A0);
        wr(12'(40 * 2 + 256), 16'h5A5A);
        m[40] = m[40] & 16'h5A5A;
        rd(12'(40 * 2), v);        chk("R11 alias program", v, m[40]);
        rd(12'(40 * 2 + 2048), v); chk("R11 alias read", v, m[40]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule